// File: doc/BRIEF.md
# Write-Unlock Command Sequence Detector

This block sits beside the page loader of a byte-wide parallel memory and decides, write by write, whether a write operation has been authorised. The loader presents each latched write strobe as a single-cycle event with its address and data. It also reports when the inter-byte timing window closes. The detector requires a fixed prefix of three command writes, each with its own address and data value. Only when that prefix has arrived in order does it open the interface. After that, every further write strobe is forwarded to the loader as real page data.

Command writes never reach storage: the detector flags them so that the loader drops their data. Their addresses stay ordinary locations that a later, unlocked write may use. A write that arrives without the full prefix stores nothing. The detector still raises a dummy-cycle request, so the loader runs a full busy period and reads during it behave as status polling. The unlocked state lasts for one write operation only. It ends when the timing window closes, which is the point where programming begins. The next operation needs the whole prefix again.

Top module: `wr_unlock_seq`

## Requirements
- R1: After reset `unlocked`, `cmd_suppress`, `wr_forward` and `dummy_busy_req` are all 0.
- R2: Three writes in order (defaults: address 0x1555 data 0xAA, then 0x0AAA/0x55, then 0x1555/0xA0) each produce a `cmd_suppress` pulse. `unlocked` goes to 1 in the same cycle as the third pulse.
- R3: A command write never produces `wr_forward` or `dummy_busy_req`, so its data is not stored.
- R4: While unlocked, every write is forwarded with `wr_forward`. This holds even for a write whose address and data equal a command step. `cmd_suppress` stays 0 for these writes.
- R5: A write while locked with no prefix in progress, and not matching step one, produces `dummy_busy_req` only, and `unlocked` stays 0.
- R6: A write that mismatches the expected step in address or in data produces `dummy_busy_req` and returns the detector to step one. A following write that would have matched the next step is then also a dummy write.
- R7: Expiry of the timing window part way through the prefix aborts it without a dummy request. The next write is compared against step one.
- R8: Expiry after at least one data byte has been forwarded clears `unlocked`. A further data write without a new prefix produces `dummy_busy_req`.
- R9: Expiry while unlocked but before any data byte clears `unlocked` as well.
- R10: When a write and a window expiry arrive in the same cycle, the expiry is applied first and the write is judged from step one.
- R11: `cmd_suppress`, `wr_forward` and `dummy_busy_req` are registered, appear in the cycle after the write event and last exactly one cycle. At most one of them is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_evt | input | 1 | One-cycle latched write strobe from the page loader |
| wr_addr | input | 13 | Address of the latched write |
| wr_data | input | 8 | Data of the latched write |
| win_expire | input | 1 | Inter-byte timing window has closed |
| unlocked | output | 1 | Current write operation is authorised |
| cmd_suppress | output | 1 | Last write was a command write; drop its data |
| wr_forward | output | 1 | Last write is real data for the page loader |
| dummy_busy_req | output | 1 | Last write was unauthorised; run a busy period without storing |

## Verification
The hardest case to reach is a write and a window expiry landing in the same cycle, at different points of the sequence. The stimulus builds a partial prefix, and separately a loaded page. It then drives the colliding cycle and checks that the write was judged from step one. A second awkward case is a write that matches a command step exactly after the unlock. The bench drives it straight after the third command write and expects a forward, not a suppress.

// File: rtl/wr_unlock_pkg.sv
package wr_unlock_pkg;

    typedef enum logic [1:0] {
        PH_ARM  = 2'd0,
        PH_OPEN = 2'd1,
        PH_LOAD = 2'd2
    } phase_e;

    function automatic int step_bits(input int steps);
        return (steps < 2) ? 1 : $clog2(steps);
    endfunction

endpackage

// File: rtl/cmd_match.sv
module cmd_match #(
    parameter int ADDR_W    = 13,
    parameter int DATA_W    = 8,
    parameter int CMD_STEPS = 3,
    parameter logic [CMD_STEPS*ADDR_W-1:0] CMD_ADDRS = '0,
    parameter logic [CMD_STEPS*DATA_W-1:0] CMD_DATAS = '0
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    data,
    output logic [CMD_STEPS-1:0] hit
);

    for (genvar i = 0; i < CMD_STEPS; i++) begin : g_step
        localparam logic [ADDR_W-1:0] EXP_A = CMD_ADDRS[i*ADDR_W +: ADDR_W];
        localparam logic [DATA_W-1:0] EXP_D = CMD_DATAS[i*DATA_W +: DATA_W];
        assign hit[i] = (addr == EXP_A) && (data == EXP_D);
    end

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import wr_unlock_pkg::*;
#(
    parameter int CMD_STEPS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_evt,
    input  logic                 win_expire,
    input  logic [CMD_STEPS-1:0] hit,
    output logic                 unlocked,
    output logic                 cmd_suppress,
    output logic                 wr_forward,
    output logic                 dummy_busy_req
);

    localparam int STEP_W = step_bits(CMD_STEPS);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(CMD_STEPS - 1);

    typedef struct packed {
        phase_e            phase;
        logic [STEP_W-1:0] step;
        logic              sup;
        logic              fwd;
        logic              dum;
    } seq_t;

    seq_t q, d;
    phase_e            eff_phase;
    logic [STEP_W-1:0] eff_step;
    logic              cur_hit;

    always_comb begin
        // expiry closes the window before any coincident write is judged
        eff_phase = win_expire ? PH_ARM : q.phase;
        eff_step  = win_expire ? '0 : q.step;

        cur_hit = 1'b0;
        for (int i = 0; i < CMD_STEPS; i++) begin
            if (eff_step == STEP_W'(i)) cur_hit = hit[i];
        end

        d       = '0;
        d.phase = eff_phase;
        d.step  = eff_step;

        if (wr_evt) begin
            unique case (eff_phase)
                PH_ARM: begin
                    if (cur_hit) begin
                        d.sup = 1'b1;
                        if (eff_step == LAST_STEP) begin
                            d.phase = PH_OPEN;
                            d.step  = '0;
                        end else begin
                            d.step = eff_step + 1'b1;
                        end
                    end else begin
                        d.dum   = 1'b1;
                        d.phase = PH_ARM;
                        d.step  = '0;
                    end
                end
                PH_OPEN, PH_LOAD: begin
                    d.fwd   = 1'b1;
                    d.phase = PH_LOAD;
                end
                default: begin
                    d.phase = PH_ARM;
                    d.step  = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_ARM, step: '0, sup: 1'b0, fwd: 1'b0, dum: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign unlocked       = (q.phase != PH_ARM);
    assign cmd_suppress   = q.sup;
    assign wr_forward     = q.fwd;
    assign dummy_busy_req = q.dum;

    p_pulse_needs_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_evt |=> !(cmd_suppress || wr_forward || dummy_busy_req));

    p_one_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_suppress, wr_forward, dummy_busy_req}));

    p_unlock_on_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> cmd_suppress);

    p_forward_only_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_forward |-> unlocked);

    p_dummy_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dummy_busy_req |-> !unlocked);

    p_expiry_locks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (win_expire && !wr_evt) |=> !unlocked);

    p_write_locked_no_fwd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_evt && !unlocked) |=> !wr_forward);

endmodule

// File: rtl/wr_unlock_seq.sv
module wr_unlock_seq #(
    parameter int ADDR_W    = 13,
    parameter int DATA_W    = 8,
    parameter int CMD_STEPS = 3,
    parameter logic [CMD_STEPS*ADDR_W-1:0] CMD_ADDRS = {13'h1555, 13'h0AAA, 13'h1555},
    parameter logic [CMD_STEPS*DATA_W-1:0] CMD_DATAS = {8'hA0, 8'h55, 8'hAA}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_evt,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              win_expire,
    output logic              unlocked,
    output logic              cmd_suppress,
    output logic              wr_forward,
    output logic              dummy_busy_req
);

    logic [CMD_STEPS-1:0] step_hit;

    cmd_match #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CMD_STEPS(CMD_STEPS),
        .CMD_ADDRS(CMD_ADDRS),
        .CMD_DATAS(CMD_DATAS)
    ) u_match (
        .addr(wr_addr),
        .data(wr_data),
        .hit (step_hit)
    );

    seq_fsm #(
        .CMD_STEPS(CMD_STEPS)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_evt        (wr_evt),
        .win_expire    (win_expire),
        .hit           (step_hit),
        .unlocked      (unlocked),
        .cmd_suppress  (cmd_suppress),
        .wr_forward    (wr_forward),
        .dummy_busy_req(dummy_busy_req)
    );

endmodule

// File: tb/tb_wr_unlock_seq.sv
module tb_wr_unlock_seq;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_evt = 1'b0;
    logic [12:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        win_expire = 1'b0;
    logic        unlocked, cmd_suppress, wr_forward, dummy_busy_req;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wr_unlock_seq dut (
        .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .wr_addr(wr_addr),
        .wr_data(wr_data), .win_expire(win_expire), .unlocked(unlocked),
        .cmd_suppress(cmd_suppress), .wr_forward(wr_forward),
        .dummy_busy_req(dummy_busy_req)
    );

    // expected packing: {unlocked, suppress, forward, dummy}
    task automatic chk(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {unlocked, cmd_suppress, wr_forward, dummy_busy_req};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {unl,sup,fwd,dum} actual=%b expected=%b", req, act, exp);
        end
    endtask

    // one write; outputs sampled on the negedge after the registering edge
    task automatic wr(input logic [12:0] a, input logic [7:0] dt, input logic exp_flag,
                      input string req, input logic [3:0] exp);
        @(negedge clk);
        wr_evt = 1'b1; wr_addr = a; wr_data = dt; win_expire = exp_flag;
        @(negedge clk);
        wr_evt = 1'b0; win_expire = 1'b0;
        chk(req, exp);
    endtask

    task automatic expire(input string req, input logic [3:0] exp);
        @(negedge clk);
        win_expire = 1'b1;
        @(negedge clk);
        win_expire = 1'b0;
        chk(req, exp);
    endtask

    task automatic idle_chk(input string req, input logic [3:0] exp);
        @(negedge clk);
        chk(req, exp);
    endtask

    task automatic prefix(input string req);
        wr(13'h1555, 8'hAA, 1'b0, req, 4'b0100);
        wr(13'h0AAA, 8'h55, 1'b0, req, 4'b0100);
        wr(13'h1555, 8'hA0, 1'b0, req, 4'b1100);
    endtask

    task automatic t_reset;
        idle_chk("R1", 4'b0000);
    endtask

    task automatic t_unlock_and_load;
        prefix("R2 R3");
        idle_chk("R11 pulse width", 4'b1000);
        wr(13'h1555, 8'hAA, 1'b0, "R4 cmd-looking data", 4'b1010);
        wr(13'h0040, 8'h3C, 1'b0, "R4", 4'b1010);
        expire("R8 expiry locks", 4'b0000);
        wr(13'h0041, 8'h77, 1'b0, "R8 re-arm needed", 4'b0001);
        idle_chk("R11 dummy width", 4'b0000);
    endtask

    task automatic t_no_prefix;
        wr(13'h0123, 8'h99, 1'b0, "R5", 4'b0001);
        wr(13'h0AAA, 8'h55, 1'b0, "R5 step two alone", 4'b0001);
    endtask

    task automatic t_mismatch;
        wr(13'h1555, 8'hAA, 1'b0, "R6 step one", 4'b0100);
        wr(13'h0AAA, 8'h56, 1'b0, "R6 data mismatch", 4'b0001);
        wr(13'h0AAA, 8'h55, 1'b0, "R6 back to step one", 4'b0001);
        wr(13'h1555, 8'hAA, 1'b0, "R6", 4'b0100);
        wr(13'h0AAA, 8'h55, 1'b0, "R6", 4'b0100);
        wr(13'h1554, 8'hA0, 1'b0, "R6 addr mismatch", 4'b0001);
        wr(13'h1555, 8'hA0, 1'b0, "R6 step three alone", 4'b0001);
    endtask

    task automatic t_abort;
        wr(13'h1555, 8'hAA, 1'b0, "R7", 4'b0100);
        expire("R7 abort no dummy", 4'b0000);
        wr(13'h0AAA, 8'h55, 1'b0, "R7 judged as step one", 4'b0001);
        wr(13'h1555, 8'hAA, 1'b0, "R7 restart", 4'b0100);
        wr(13'h0AAA, 8'h55, 1'b0, "R7", 4'b0100);
        expire("R7 abort at step three", 4'b0000);
        wr(13'h1555, 8'hA0, 1'b0, "R7 step three alone", 4'b0001);
    endtask

    task automatic t_open_expire;
        prefix("R2");
        expire("R9 expiry before data", 4'b0000);
        wr(13'h0200, 8'h11, 1'b0, "R9 data after expiry", 4'b0001);
    endtask

    task automatic t_collide;
        wr(13'h1555, 8'hAA, 1'b0, "R10", 4'b0100);
        wr(13'h0AAA, 8'h55, 1'b1, "R10 expiry with step two", 4'b0001);
        wr(13'h1555, 8'hAA, 1'b0, "R10", 4'b0100);
        wr(13'h1555, 8'hAA, 1'b1, "R10 expiry with step one", 4'b0100);
        wr(13'h0AAA, 8'h55, 1'b0, "R10", 4'b0100);
        wr(13'h1555, 8'hA0, 1'b0, "R10", 4'b1100);
        wr(13'h0300, 8'h22, 1'b0, "R10 data", 4'b1010);
        wr(13'h0301, 8'h23, 1'b1, "R10 expiry with late data", 4'b0001);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        idle_chk("R1 after release", 4'b0000);
        t_unlock_and_load();
        t_no_prefix();
        t_mismatch();
        t_abort();
        t_open_expire();
        t_collide();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule